// File: doc/BRIEF.md
# Banked Fault Address Register Access Controller

This block holds the 32-bit virtual address of the instruction fetch that caused the most recent synchronous prefetch abort. The address is kept in two storage slots, a secure slot and a non-secure slot. When the hardware captures a fault, the address is loaded into the slot that matches the current security state. Software reads and writes arrive as coprocessor-style move-from and move-to operations.

For each access the block decides combinationally what happens. The access may be undefined. It may be trapped to the hypervisor, with the trap form and syndrome class reported. Otherwise it is allowed, and it is steered to one of the two slots. The outcome depends on the privilege level, the configuration of levels 2 and 3, the hypervisor trap bits and the non-secure bit. Read data is returned one cycle later from a register.

Top module: `fault_addr_bank`

## Requirements
- R1: The block responds only when `acc_valid_i` is 1 and the access fields match coprocessor 15, opc1=0, CRn=6, CRm=0, opc2=2. Any other access raises neither `undef_o` nor `trap_o`, modifies no slot, and leaves `rdata_o` at zero.
- R2: A matching access is undefined (`undef_o`=1, `trap_o`=0) when `l1_narrow_i`=0 or `lvl_i`=0. Undefined takes priority over every trap bit.
- R3: At `lvl_i`=1 with `l2_en_i`=1, the CRn-6 trap bit of the form that matches level 2 traps the access: the wide bit when `l2_narrow_i`=0, the narrow bit when it is 1. The bit of the other form has no effect.
- R4: A read is trapped by the read virtual-memory trap bit, and a write by the write virtual-memory trap bit, again in the form that matches level 2. The bit for the opposite direction has no effect.
- R5: While `trap_o`=1, `trap_kind_o` is 0 (system-access trap) when level 2 is wide and 1 (hypervisor trap exception) when it is narrow, and `trap_class_o` is 6'h03. Without a trap, `trap_class_o` is zero.
- R6: No trap is raised at `lvl_i`=2 or 3, nor at `lvl_i`=1 when `l2_en_i`=0.
- R7: At levels 1 and 2, an allowed access targets the non-secure slot when `l3_present_i` and `l3_narrow_i` are both 1. Otherwise it targets the common slot, which is the storage read as the secure slot.
- R8: At level 3, an allowed access targets the secure slot when `nonsec_i`=0 and the non-secure slot when `nonsec_i`=1.
- R9: An undefined or trapped write changes neither slot. An undefined or trapped read returns zero on `rdata_o`.
- R10: When `abort_i`=1, `abort_addr_i` is loaded at the clock edge. It goes into the slot selected by `nonsec_i` when level 3 is present and narrow, and into the common slot otherwise.
- R11: A capture and a write to the same slot in one cycle leave the captured address in that slot. When they target different slots, both slots are updated.
- R12: After reset, both slots hold zero and `rdata_o` is zero.
- R13: `undef_o`, `trap_o` and the trap fields are valid in the same cycle as the access. `rdata_o` shows the selected slot's pre-edge content after the edge that ends an allowed read, and shows zero after any edge without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| cp_num_i | input | 4 | Coprocessor number of the access |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register field |
| crm_i | input | 4 | Secondary register field |
| opc2_i | input | 3 | Second opcode field |
| wdata_i | input | 32 | Write data |
| lvl_i | input | 2 | Current privilege level 0..3 |
| l1_narrow_i | input | 1 | Level 1 can use the 32-bit state |
| l2_en_i | input | 1 | Level 2 enabled |
| l2_narrow_i | input | 1 | Level 2 uses the 32-bit state |
| l3_present_i | input | 1 | Level 3 implemented |
| l3_narrow_i | input | 1 | Level 3 uses the 32-bit state |
| crn6_trap_wide_i | input | 1 | CRn-6 access trap bit, 64-bit hypervisor form |
| crn6_trap_narrow_i | input | 1 | CRn-6 access trap bit, 32-bit hypervisor form |
| rd_vm_trap_wide_i | input | 1 | Read virtual-memory trap bit, 64-bit form |
| rd_vm_trap_narrow_i | input | 1 | Read virtual-memory trap bit, 32-bit form |
| wr_vm_trap_wide_i | input | 1 | Write virtual-memory trap bit, 64-bit form |
| wr_vm_trap_narrow_i | input | 1 | Write virtual-memory trap bit, 32-bit form |
| nonsec_i | input | 1 | Non-secure bit of the secure configuration |
| abort_i | input | 1 | Prefetch-abort capture pulse |
| abort_addr_i | input | 32 | Faulting virtual address |
| undef_o | output | 1 | Access is undefined |
| trap_o | output | 1 | Access traps to the hypervisor |
| trap_kind_o | output | 1 | 0 = system-access trap, 1 = hypervisor trap exception |
| trap_class_o | output | 6 | Syndrome class, 6'h03 while trapping |
| rdata_o | output | 32 | Registered read data |

## Verification
The undefined flag, the trap request, its form and its class depend only on the inputs of the current cycle. The bench samples them 1 ns after it drives an access, before the next rising edge. Read data passes through one register, so it is sampled 1 ns after the edge that ends the read. A separate check confirms that the value has not yet appeared before that edge, and that it returns to zero one idle edge later. The effect of a write or a capture becomes visible only through a later read, so each of those checks is made two edges after the stimulus.

// File: rtl/fab_pkg.sv
package fab_pkg;
  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;
  localparam int unsigned NCOPY = 2;
  localparam int unsigned SEL_W = (NCOPY > 1) ? $clog2(NCOPY) : 1;
  localparam logic [SEL_W-1:0] SLOT_SEC  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SLOT_NSEC = SEL_W'(1);
  localparam logic TRAP_SYS_ACCESS = 1'b0;
  localparam logic TRAP_HYP_EXC    = 1'b1;
  localparam logic [5:0] TRAP_CLASS = 6'h03;
endpackage

// File: rtl/fab_enc_match.sv
module fab_enc_match #(
  parameter logic [3:0] CP_NUM = 4'd15,
  parameter logic [2:0] OPC1   = 3'd0,
  parameter logic [3:0] CRN    = 4'd6,
  parameter logic [3:0] CRM    = 4'd0,
  parameter logic [2:0] OPC2   = 3'd2
) (
  input  logic       valid_i,
  input  logic [3:0] cp_num_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output logic       hit_o
);
  assign hit_o = valid_i && (cp_num_i == CP_NUM) && (opc1_i == OPC1) &&
                 (crn_i == CRN) && (crm_i == CRM) && (opc2_i == OPC2);
endmodule

// File: rtl/fab_access_ctrl.sv
module fab_access_ctrl
  import fab_pkg::*;
(
  input  logic             hit_i,
  input  logic             write_i,
  input  logic [1:0]       lvl_i,
  input  logic             l1_narrow_i,
  input  logic             l2_en_i,
  input  logic             l2_narrow_i,
  input  logic             l3_present_i,
  input  logic             l3_narrow_i,
  input  logic             crn6_wide_i,
  input  logic             crn6_narrow_i,
  input  logic             rd_vm_wide_i,
  input  logic             rd_vm_narrow_i,
  input  logic             wr_vm_wide_i,
  input  logic             wr_vm_narrow_i,
  input  logic             nonsec_i,
  output logic             undef_o,
  output logic             trap_o,
  output logic             trap_kind_o,
  output logic [5:0]       trap_class_o,
  output logic             allow_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [SEL_W-1:0] cap_sel_o
);
  logic banked;
  logic l2_wide_on, l2_narrow_on;
  logic vm_wide, vm_narrow;
  logic [SEL_W-1:0] sec_sel;

  assign banked       = l3_present_i && l3_narrow_i;
  assign l2_wide_on   = l2_en_i && !l2_narrow_i;
  assign l2_narrow_on = l2_en_i && l2_narrow_i;
  assign vm_wide      = write_i ? wr_vm_wide_i   : rd_vm_wide_i;
  assign vm_narrow    = write_i ? wr_vm_narrow_i : rd_vm_narrow_i;
  assign sec_sel      = nonsec_i ? SLOT_NSEC : SLOT_SEC;

  always_comb begin
    undef_o     = 1'b0;
    trap_o      = 1'b0;
    trap_kind_o = TRAP_SYS_ACCESS;
    sel_o       = SLOT_SEC;
    if (hit_i) begin
      if (!l1_narrow_i || lvl_i == LVL0) begin
        undef_o = 1'b1;
      end else if (lvl_i == LVL1) begin
        // fixed priority: CRn-6 trap before virtual-memory trap, wide before narrow
        if (l2_wide_on && crn6_wide_i) begin
          trap_o = 1'b1;
        end else if (l2_narrow_on && crn6_narrow_i) begin
          trap_o = 1'b1; trap_kind_o = TRAP_HYP_EXC;
        end else if (l2_wide_on && vm_wide) begin
          trap_o = 1'b1;
        end else if (l2_narrow_on && vm_narrow) begin
          trap_o = 1'b1; trap_kind_o = TRAP_HYP_EXC;
        end else begin
          sel_o = banked ? SLOT_NSEC : SLOT_SEC;
        end
      end else if (lvl_i == LVL2) begin
        sel_o = banked ? SLOT_NSEC : SLOT_SEC;
      end else begin
        sel_o = sec_sel;
      end
    end
  end

  assign trap_class_o = trap_o ? TRAP_CLASS : 6'h00;
  assign allow_o      = hit_i && !undef_o && !trap_o;
  assign cap_sel_o    = banked ? sec_sel : SLOT_SEC;
endmodule

// File: rtl/fab_bank_regs.sv
module fab_bank_regs
  import fab_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             cap_en_i,
  input  logic [SEL_W-1:0] cap_sel_i,
  input  logic [W-1:0]     cap_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o
);
  logic [NCOPY-1:0][W-1:0] copy_q;

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    logic [W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     val_q <= '0;
      else if (cap_en_i && cap_sel_i == SEL_W'(g))     val_q <= cap_data_i;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))       val_q <= wr_data_i;
    end
    assign copy_q[g] = val_q;
  end

  assign rd_data_o = copy_q[rd_sel_i];

  // R9: without write or capture both slots hold
  a_r9_slots_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !cap_en_i) |=> $stable(copy_q));

  // R11: capture wins over a write to the same slot
  a_r11_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && wr_en_i && cap_sel_i == wr_sel_i) |=>
      copy_q[$past(cap_sel_i)] == $past(cap_data_i));
endmodule

// File: rtl/fault_addr_bank.sv
module fault_addr_bank
  import fab_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [3:0]  CP_NUM = 4'd15,
  parameter logic [2:0]  OPC1   = 3'd0,
  parameter logic [3:0]  CRN    = 4'd6,
  parameter logic [3:0]  CRM    = 4'd0,
  parameter logic [2:0]  OPC2   = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [3:0]        cp_num_i,
  input  logic [2:0]        opc1_i,
  input  logic [3:0]        crn_i,
  input  logic [3:0]        crm_i,
  input  logic [2:0]        opc2_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [1:0]        lvl_i,
  input  logic              l1_narrow_i,
  input  logic              l2_en_i,
  input  logic              l2_narrow_i,
  input  logic              l3_present_i,
  input  logic              l3_narrow_i,
  input  logic              crn6_trap_wide_i,
  input  logic              crn6_trap_narrow_i,
  input  logic              rd_vm_trap_wide_i,
  input  logic              rd_vm_trap_narrow_i,
  input  logic              wr_vm_trap_wide_i,
  input  logic              wr_vm_trap_narrow_i,
  input  logic              nonsec_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] abort_addr_i,
  output logic              undef_o,
  output logic              trap_o,
  output logic              trap_kind_o,
  output logic [5:0]        trap_class_o,
  output logic [ADDR_W-1:0] rdata_o
);
  logic             hit, allow;
  logic [SEL_W-1:0] sel, cap_sel;
  logic [ADDR_W-1:0] bank_rd, rdata_q;

  fab_enc_match #(
    .CP_NUM(CP_NUM), .OPC1(OPC1), .CRN(CRN), .CRM(CRM), .OPC2(OPC2)
  ) u_match (
    .valid_i(acc_valid_i), .cp_num_i(cp_num_i), .opc1_i(opc1_i),
    .crn_i(crn_i), .crm_i(crm_i), .opc2_i(opc2_i), .hit_o(hit)
  );

  fab_access_ctrl u_ctrl (
    .hit_i(hit), .write_i(acc_write_i), .lvl_i(lvl_i),
    .l1_narrow_i(l1_narrow_i), .l2_en_i(l2_en_i), .l2_narrow_i(l2_narrow_i),
    .l3_present_i(l3_present_i), .l3_narrow_i(l3_narrow_i),
    .crn6_wide_i(crn6_trap_wide_i), .crn6_narrow_i(crn6_trap_narrow_i),
    .rd_vm_wide_i(rd_vm_trap_wide_i), .rd_vm_narrow_i(rd_vm_trap_narrow_i),
    .wr_vm_wide_i(wr_vm_trap_wide_i), .wr_vm_narrow_i(wr_vm_trap_narrow_i),
    .nonsec_i(nonsec_i),
    .undef_o(undef_o), .trap_o(trap_o), .trap_kind_o(trap_kind_o),
    .trap_class_o(trap_class_o), .allow_o(allow), .sel_o(sel), .cap_sel_o(cap_sel)
  );

  fab_bank_regs #(.W(ADDR_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(allow && acc_write_i), .wr_sel_i(sel), .wr_data_i(wdata_i),
    .cap_en_i(abort_i), .cap_sel_i(cap_sel), .cap_data_i(abort_addr_i),
    .rd_sel_i(sel), .rd_data_o(bank_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rdata_q <= '0;
    else if (allow && !acc_write_i) rdata_q <= bank_rd;
    else                            rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!undef_o && !trap_o));
  a_r2_undef_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !trap_o);
  a_r5_trap_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_class_o == 6'h03 && trap_kind_o == l2_narrow_i));
  a_r6_trap_at_l1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (lvl_i == LVL1 && l2_en_i));
  a_r9_blocked_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && (undef_o || trap_o)) |=> rdata_o == '0);
  a_r13_write_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> rdata_o == '0);
endmodule

// File: tb/fault_addr_bank_tb.sv
`timescale 1ns/1ps
module fault_addr_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        acc_valid = 0, acc_write = 0;
  logic [3:0]  cp_num = 4'd15, crn = 4'd6, crm = 4'd0;
  logic [2:0]  opc1 = 3'd0, opc2 = 3'd2;
  logic [31:0] wdata = '0, abort_addr = '0;
  logic [1:0]  lvl = 2'd3;
  logic l1n = 1, l2en = 0, l2n = 0, l3p = 1, l3n = 1;
  logic c6w = 0, c6n = 0, rvw = 0, rvn = 0, wvw = 0, wvn = 0;
  logic ns = 0, abort = 0;
  logic        undef, trap, kind;
  logic [5:0]  tclass;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  fault_addr_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .cp_num_i(cp_num), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .wdata_i(wdata), .lvl_i(lvl), .l1_narrow_i(l1n), .l2_en_i(l2en),
    .l2_narrow_i(l2n), .l3_present_i(l3p), .l3_narrow_i(l3n),
    .crn6_trap_wide_i(c6w), .crn6_trap_narrow_i(c6n),
    .rd_vm_trap_wide_i(rvw), .rd_vm_trap_narrow_i(rvn),
    .wr_vm_trap_wide_i(wvw), .wr_vm_trap_narrow_i(wvn),
    .nonsec_i(ns), .abort_i(abort), .abort_addr_i(abort_addr),
    .undef_o(undef), .trap_o(trap), .trap_kind_o(kind),
    .trap_class_o(tclass), .rdata_o(rdata)
  );

  // row: {lvl[1:0], l1n, l2en, l2n, l3p, l3n, c6w, c6n, rvw, rvn, wvw, wvn, ns, wr, undef, trap, kind}
  localparam int NV = 17;
  localparam logic [17:0] VEC [0:NV-1] = '{
    18'b00_1_1_0_0_0_000000_0_0_100, // R2 level 0
    18'b01_0_1_0_0_0_000000_0_0_100, // R2 level 1 not narrow-capable
    18'b01_1_1_0_0_0_100000_0_0_010, // R3 wide crn6
    18'b01_1_1_1_0_0_010000_0_1_011, // R3 narrow crn6, R5 hyp form
    18'b01_1_1_0_0_0_010000_0_0_000, // R3 wrong-form bit ignored
    18'b01_1_1_0_0_0_001000_0_0_010, // R4 read vm wide
    18'b01_1_1_0_0_0_001000_0_1_000, // R4 read bit on write ignored
    18'b01_1_1_0_0_0_000010_0_1_010, // R4 write vm wide
    18'b01_1_1_0_0_0_000010_0_0_000, // R4 write bit on read ignored
    18'b01_1_1_1_0_0_000100_0_0_011, // R4 read vm narrow
    18'b01_1_1_1_0_0_000001_0_1_011, // R4 write vm narrow
    18'b01_1_0_0_0_0_111111_0_0_000, // R6 level 2 disabled
    18'b10_1_1_0_0_0_111111_0_0_000, // R6 level 2
    18'b11_1_1_0_1_1_111111_0_0_000, // R6 level 3
    18'b00_1_1_0_0_0_111111_0_0_100, // R2 undef beats traps
    18'b01_0_1_0_0_0_111111_0_0_100, // R2 undef beats traps
    18'b01_1_1_0_0_0_000100_0_0_000  // R4 narrow bit with wide level 2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    l1n = 1; l2en = 0; l2n = 0; l3p = 1; l3n = 1;
    c6w = 0; c6n = 0; rvw = 0; rvn = 0; wvw = 0; wvn = 0;
  endtask

  task automatic wr(input logic [1:0] l, input logic s, input logic [31:0] d);
    @(negedge clk);
    lvl = l; ns = s; acc_valid = 1; acc_write = 1; wdata = d;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [1:0] l, input logic s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    lvl = l; ns = s; acc_valid = 1; acc_write = 0;
    @(posedge clk); #1;
    acc_valid = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic cap(input logic s, input logic [31:0] a);
    @(negedge clk);
    ns = s; abort = 1; abort_addr = a;
    @(posedge clk); #1;
    abort = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R12 rdata after reset", rdata, 32'h0);
    chk("R12 undef idle", {31'h0, undef}, 32'h0);
    rd(2'd3, 1'b0, 32'h0, "R12 secure slot reset");
    rd(2'd3, 1'b1, 32'h0, "R12 non-secure slot reset");

    // decision table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {lvl, l1n, l2en, l2n, l3p, l3n, c6w, c6n, rvw, rvn, wvw, wvn, ns, acc_write} = VEC[i][17:3];
      wdata = 32'h5A00_0000 | i;
      acc_valid = 1;
      #1;
      chk($sformatf("R2 undef row %0d", i), {31'h0, undef}, {31'h0, VEC[i][2]});
      chk($sformatf("R3 trap row %0d", i), {31'h0, trap}, {31'h0, VEC[i][1]});
      if (VEC[i][1]) begin
        chk($sformatf("R5 kind row %0d", i), {31'h0, kind}, {31'h0, VEC[i][0]});
      end
      chk($sformatf("R5 class row %0d", i), {26'h0, tclass}, VEC[i][1] ? 32'h3 : 32'h0);
      @(posedge clk); #1;
      acc_valid = 0; acc_write = 0;
      if (VEC[i][2] || VEC[i][1]) chk($sformatf("R9 blocked read row %0d", i), rdata, 32'h0);
    end
    clear_cfg();

    // R8 level 3 selection by nonsec bit
    wr(2'd3, 1'b0, 32'h1111_0000);
    wr(2'd3, 1'b1, 32'h2222_0000);
    rd(2'd3, 1'b0, 32'h1111_0000, "R8 secure slot");
    rd(2'd3, 1'b1, 32'h2222_0000, "R8 non-secure slot");

    // R7 levels 1/2 banked -> non-secure, else common (secure storage)
    wr(2'd1, 1'b0, 32'h3333_0000);
    rd(2'd3, 1'b1, 32'h3333_0000, "R7 banked write to non-secure");
    rd(2'd3, 1'b0, 32'h1111_0000, "R7 secure untouched");
    l3n = 0;
    wr(2'd2, 1'b1, 32'h4444_0000);
    l3n = 1;
    rd(2'd3, 1'b0, 32'h4444_0000, "R7 common slot write");
    rd(2'd3, 1'b1, 32'h3333_0000, "R7 non-secure untouched");

    // R9 blocked writes
    l2en = 1; wvw = 1;
    wr(2'd1, 1'b0, 32'hDEAD_0001);
    clear_cfg();
    wr(2'd0, 1'b1, 32'hDEAD_0002);
    rd(2'd3, 1'b1, 32'h3333_0000, "R9 trapped/undef write non-secure");
    rd(2'd3, 1'b0, 32'h4444_0000, "R9 trapped/undef write secure");

    // R1 encoding mismatch
    @(negedge clk);
    lvl = 2'd0; crn = 4'd5; acc_valid = 1;
    #1;
    chk("R1 no undef on mismatch", {31'h0, undef}, 32'h0);
    acc_valid = 0;
    wr(2'd3, 1'b0, 32'hBAD0_0001);
    cp_num = 4'd14; crn = 4'd6;
    wr(2'd3, 1'b0, 32'hBAD0_0002);
    rd(2'd3, 1'b0, 32'h0, "R1 mismatched read gives zero");
    cp_num = 4'd15;
    rd(2'd3, 1'b0, 32'h4444_0000, "R1 mismatched writes ignored");

    // R10 capture
    cap(1'b1, 32'hF000_0001);
    rd(2'd3, 1'b1, 32'hF000_0001, "R10 capture non-secure");
    rd(2'd3, 1'b0, 32'h4444_0000, "R10 secure untouched");
    cap(1'b0, 32'hF000_0002);
    rd(2'd3, 1'b0, 32'hF000_0002, "R10 capture secure");
    l3n = 0;
    cap(1'b1, 32'hF000_0003);
    l3n = 1;
    rd(2'd3, 1'b0, 32'hF000_0003, "R10 unbanked capture to common");
    rd(2'd3, 1'b1, 32'hF000_0001, "R10 non-secure untouched");

    // R11 same-slot collision
    @(negedge clk);
    lvl = 2'd3; ns = 0; acc_valid = 1; acc_write = 1; wdata = 32'hAAAA_0000;
    abort = 1; abort_addr = 32'hCCCC_0001;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; abort = 0;
    rd(2'd3, 1'b0, 32'hCCCC_0001, "R11 capture wins");
    // R11 different slots
    @(negedge clk);
    lvl = 2'd1; ns = 0; acc_valid = 1; acc_write = 1; wdata = 32'hAAAA_0002;
    abort = 1; abort_addr = 32'hCCCC_0002;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0; abort = 0;
    rd(2'd3, 1'b1, 32'hAAAA_0002, "R11 write lands non-secure");
    rd(2'd3, 1'b0, 32'hCCCC_0002, "R11 capture lands secure");

    // R13 read timing
    repeat (2) @(posedge clk);
    #1;
    chk("R13 idle rdata zero", rdata, 32'h0);
    @(negedge clk);
    lvl = 2'd3; ns = 0; acc_valid = 1; acc_write = 0;
    #1;
    chk("R13 not before edge", rdata, 32'h0);
    @(posedge clk); #1;
    acc_valid = 0;
    chk("R13 after edge", rdata, 32'hCCCC_0002);
    @(posedge clk); #1;
    chk("R13 back to zero", rdata, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule